// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block controls sixteen general-purpose pins, split into two banks of eight. A host reaches it through a synchronous byte-wide register port. Every pin has two registers. The output-control register sets direction, output value, open-drain selection and the pull configuration. The input-control register returns the synchronised pin level and holds the pin's edge-detect mode.

Pin inputs pass through a two-flop synchroniser. The synchronised level is then compared with its value one clock earlier, so that falling, rising or both edges can be detected. A detected edge sets a bit in the pin's bank pending register. The host clears that bit by writing a one to it. Per-bank mask registers can hide pending bits from the single registered interrupt line. The pull and open-drain settings are only stored and driven out as static configuration outputs for the pad ring.

Top module: `edge_gpio_ctrl`

## Requirements
- R1: After reset every register reads 0x00, and `pin_oe`, `pin_out` and `irq` are all 0.
- R2: The output-control register for in-bank index n sits at 0x2B+n (pins 0-7) and at 0x3B+n (pins 8-15). It reads back as written. Its bits drive the pin outputs as follows: bit 0 drives `pin_out`, bits 2:1 drive the pin's two-bit slice of `pull_sel`, bit 3 drives `pull_en` and bit 4 drives `open_drain`.
- R3: Bit 5 of the output-control register is direction, with 1 meaning output, and `pin_oe` follows it. When bit 4 (open-drain) is also set, `pin_oe` is 1 only while bit 0 is 0.
- R4: The input-control register sits at 0x33+n (pins 0-7) and at 0x43+n (pins 8-15). Bit 0 reads the pin level after the two-flop synchroniser. Bits 2:1 read back the stored edge mode. Bits 7:3 read 0.
- R5: With edge mode 01 (falling), a 1-to-0 transition of the synchronised level sets the pin's pending bit, and a 0-to-1 transition does not.
- R6: With edge mode 10 (rising), a 0-to-1 transition sets the pending bit, and a 1-to-0 transition does not.
- R7: With edge mode 11, both transitions set the pending bit. With mode 00, neither does.
- R8: The pending registers sit at 0x0B (bank 0) and 0x0C (bank 1), with bit n for in-bank index n. Writing 1 to a bit clears it. Writing 0 to a bit leaves it unchanged.
- R9: If an edge is detected in the same cycle that a clearing write hits the same pending bit, the bit stays set.
- R10: The mask registers sit at 0x19 (bank 0) and 0x1A (bank 1). A mask bit of 1 keeps its pending bit off `irq`, but the pending bit still reads back as set.
- R11: `irq` is a registered level, equal to the OR over all pins of (pending AND NOT mask) as it stood on the previous clock. A pin edge therefore reaches `irq` on the fourth rising clock edge after the pin changes.
- R12: The secondary mask registers at 0x1B and 0x1C read back as written and have no effect on `irq`.
- R13: A read of an address that maps to no register returns 0x00, and a write to one changes nothing. No write can set a pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe, captured at the rising edge |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; `rdata` updates at the same edge |
| rdata | output | 8 | Registered read data, held between reads |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output value per pin |
| pin_oe | output | 16 | Output enable per pin |
| open_drain | output | 16 | Stored open-drain selection per pin |
| pull_en | output | 16 | Stored pull enable per pin |
| pull_sel | output | 32 | Stored two-bit pull type per pin; pin i at bits 2i+1:2i |
| irq | output | 1 | Registered interrupt level |

## Verification
Edge capture and the host's write-one-to-clear of a pending bit can fall on the same clock edge. The bench sets this up with a pending bit that is already high. It toggles that pin and then drives the clearing write two clocks later, so the write is captured on the edge where the synchronised level first differs from its previous value. The pending register must still read the bit as set afterwards, and a second clearing write with no edge in flight must clear it. A mask update while a bit is pending is also checked: `irq` must drop with the pending bit still readable, and must return after the mask is removed.

// File: rtl/edge_gpio_pkg.sv
package edge_gpio_pkg;

   localparam int unsigned DATA_W = 8;

   // output-control field positions
   localparam int unsigned OC_VAL  = 0;
   localparam int unsigned OC_PSLO = 1;
   localparam int unsigned OC_PEN  = 3;
   localparam int unsigned OC_OD   = 4;
   localparam int unsigned OC_DIR  = 5;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_RISE = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_mode_e;

endpackage

// File: rtl/edge_gpio_sync.sv
module edge_gpio_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("edge_gpio_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] st_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) st_q[k] <= '0;
      end else begin
         st_q[0] <= din;
         for (int k = 1; k < STAGES; k++) st_q[k] <= st_q[k-1];
      end
   end

   assign dout = st_q[STAGES-1];

endmodule

// File: rtl/edge_gpio_detect.sv
module edge_gpio_detect
   import edge_gpio_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [WIDTH-1:0]   lvl,
   input  logic [2*WIDTH-1:0] mode,
   output logic [WIDTH-1:0]   hit
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic rise, fall, h;
      assign rise = lvl[i] & ~prev_q[i];
      assign fall = ~lvl[i] & prev_q[i];
      always_comb begin
         case (edge_mode_e'(mode[2*i +: 2]))
            EDGE_OFF:  h = 1'b0;
            EDGE_FALL: h = fall;
            EDGE_RISE: h = rise;
            default:   h = rise | fall;
         endcase
      end
      assign hit[i] = h;
   end

endmodule

// File: rtl/edge_gpio_irq.sv
module edge_gpio_irq #(
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned BANK_W    = 8,
   localparam int unsigned NPINS    = NUM_BANKS * BANK_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NPINS-1:0]     hit,
   input  logic [NPINS-1:0]     clr,
   input  logic [NUM_BANKS-1:0] mask_we,
   input  logic [BANK_W-1:0]    wdata,
   output logic [NPINS-1:0]     pend,
   output logic [NPINS-1:0]     mask,
   output logic                 irq
);

   logic [NPINS-1:0] pend_q;
   logic [NPINS-1:0] mask_q;
   logic             irq_q;

   // a fresh edge outranks a clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr) | hit;
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk) begin
         if (!rst_n)          mask_q[b*BANK_W +: BANK_W] <= '0;
         else if (mask_we[b]) mask_q[b*BANK_W +: BANK_W] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(pend_q & ~mask_q);
   end

   assign pend = pend_q;
   assign mask = mask_q;
   assign irq  = irq_q;

endmodule

// File: rtl/edge_gpio_ctrl.sv
module edge_gpio_ctrl
   import edge_gpio_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 2,
   parameter int unsigned BANK_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PEND_BASE   = 'h0B,
   parameter int unsigned MASK_BASE   = 'h19,
   parameter int unsigned MASK2_BASE  = 'h1B,
   parameter int unsigned CTLO_BASE   = 'h2B,
   parameter int unsigned CTLI_BASE   = 'h33,
   parameter int unsigned BANK_STRIDE = 'h10,
   localparam int unsigned NPINS      = NUM_BANKS * BANK_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [7:0]         addr,
   input  logic               wr_en,
   input  logic [7:0]         wdata,
   input  logic               rd_en,
   output logic [7:0]         rdata,
   input  logic [NPINS-1:0]   pin_in,
   output logic [NPINS-1:0]   pin_out,
   output logic [NPINS-1:0]   pin_oe,
   output logic [NPINS-1:0]   open_drain,
   output logic [NPINS-1:0]   pull_en,
   output logic [2*NPINS-1:0] pull_sel,
   output logic               irq
);

   if (BANK_W != DATA_W) begin : g_bad_width
      $error("edge_gpio_ctrl: BANK_W must equal the register width");
   end
   if (NUM_BANKS < 1 || NUM_BANKS > 2) begin : g_bad_banks
      $error("edge_gpio_ctrl: NUM_BANKS must be 1 or 2");
   end

   function automatic logic [7:0] pin_addr(input int unsigned base, input int unsigned pin);
      return 8'(base + (pin / BANK_W) * BANK_STRIDE + (pin % BANK_W));
   endfunction

   function automatic logic [7:0] bank_addr(input int unsigned base, input int unsigned bank);
      return 8'(base + bank);
   endfunction

   logic [7:0]            ctlo_q  [NPINS];
   logic [1:0]            mode_q  [NPINS];
   logic [BANK_W-1:0]     mask2_q [NUM_BANKS];
   logic [NPINS-1:0]      lvl_w;
   logic [NPINS-1:0]      hit_w;
   logic [NPINS-1:0]      clr_w;
   logic [NPINS-1:0]      pend_w;
   logic [NPINS-1:0]      mask_w;
   logic [2*NPINS-1:0]    mode_flat;
   logic [NUM_BANKS-1:0]  mask_we;
   logic [7:0]            rd_mux;
   logic [7:0]            rdata_q;

   edge_gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_in),
      .dout (lvl_w)
   );

   edge_gpio_detect #(.WIDTH(NPINS)) i_detect (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (lvl_w),
      .mode (mode_flat),
      .hit  (hit_w)
   );

   edge_gpio_irq #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) i_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (hit_w),
      .clr    (clr_w),
      .mask_we(mask_we),
      .wdata  (wdata),
      .pend   (pend_w),
      .mask   (mask_w),
      .irq    (irq)
   );

   // per-pin control registers and pad outputs
   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      localparam logic [7:0] A_OUT = pin_addr(CTLO_BASE, i);
      localparam logic [7:0] A_IN  = pin_addr(CTLI_BASE, i);
      localparam logic [7:0] A_PND = bank_addr(PEND_BASE, i / BANK_W);

      always_ff @(posedge clk) begin
         if (!rst_n)                      ctlo_q[i] <= '0;
         else if (wr_en && addr == A_OUT) ctlo_q[i] <= wdata;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)                     mode_q[i] <= EDGE_OFF;
         else if (wr_en && addr == A_IN) mode_q[i] <= wdata[2:1];
      end

      assign clr_w[i]          = wr_en && (addr == A_PND) && wdata[i % BANK_W];
      assign mode_flat[2*i +: 2] = mode_q[i];
      assign pin_out[i]        = ctlo_q[i][OC_VAL];
      assign open_drain[i]     = ctlo_q[i][OC_OD];
      assign pull_en[i]        = ctlo_q[i][OC_PEN];
      assign pull_sel[2*i +: 2] = ctlo_q[i][OC_PSLO +: 2];
      assign pin_oe[i]         = ctlo_q[i][OC_DIR] &
                                 ~(ctlo_q[i][OC_OD] & ctlo_q[i][OC_VAL]);
   end

   // per-bank mask strobes and secondary mask storage
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam logic [7:0] A_MSK  = bank_addr(MASK_BASE, b);
      localparam logic [7:0] A_MSK2 = bank_addr(MASK2_BASE, b);

      assign mask_we[b] = wr_en && (addr == A_MSK);

      always_ff @(posedge clk) begin
         if (!rst_n)                       mask2_q[b] <= '0;
         else if (wr_en && addr == A_MSK2) mask2_q[b] <= wdata;
      end
   end

   // read decode; unmapped addresses fall through to zero
   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NPINS; i++) begin
         if (addr == pin_addr(CTLO_BASE, i)) rd_mux = ctlo_q[i];
         if (addr == pin_addr(CTLI_BASE, i)) rd_mux = {5'b0, mode_q[i], lvl_w[i]};
      end
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (addr == bank_addr(PEND_BASE, b))  rd_mux = pend_w[b*BANK_W +: BANK_W];
         if (addr == bank_addr(MASK_BASE, b))  rd_mux = mask_w[b*BANK_W +: BANK_W];
         if (addr == bank_addr(MASK2_BASE, b)) rd_mux = mask2_q[b];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata_q <= '0;
      else if (rd_en) rdata_q <= rd_mux;
   end

   assign rdata = rdata_q;

endmodule

// File: rtl/edge_gpio_ctrl_chk.sv
module edge_gpio_ctrl_chk #(
   parameter int unsigned NUM_BANKS   = 2,
   parameter int unsigned BANK_W      = 8,
   parameter int unsigned PEND_BASE   = 'h0B,
   parameter int unsigned MASK_BASE   = 'h19,
   parameter int unsigned MASK2_BASE  = 'h1B,
   parameter int unsigned CTLO_BASE   = 'h2B,
   parameter int unsigned CTLI_BASE   = 'h33,
   parameter int unsigned BANK_STRIDE = 'h10,
   localparam int unsigned NPINS      = NUM_BANKS * BANK_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       addr,
   input logic             rd_en,
   input logic [7:0]       rdata,
   input logic [NPINS-1:0] pend,
   input logic [NPINS-1:0] mask,
   input logic [NPINS-1:0] hit,
   input logic [NPINS-1:0] clr,
   input logic [NPINS-1:0] pin_out,
   input logic [NPINS-1:0] pin_oe,
   input logic [NPINS-1:0] open_drain,
   input logic             irq
);

   logic mapped;

   always_comb begin
      mapped = 1'b0;
      for (int i = 0; i < NPINS; i++) begin
         if (addr == 8'(CTLO_BASE + (i / BANK_W) * BANK_STRIDE + (i % BANK_W))) mapped = 1'b1;
         if (addr == 8'(CTLI_BASE + (i / BANK_W) * BANK_STRIDE + (i % BANK_W))) mapped = 1'b1;
      end
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (addr == 8'(PEND_BASE + b) || addr == 8'(MASK_BASE + b) ||
             addr == 8'(MASK2_BASE + b)) mapped = 1'b1;
      end
   end

   AST_PEND_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(pend) & ~$past(clr)) & ~pend) == '0); // R9

   AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend & ~$past(pend)) & ~$past(hit)) == '0); // R5

   AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend & ~mask)) |=> irq); // R11

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(|(pend & ~mask))); // R10

   AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & open_drain & pin_out) == '0); // R3

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !mapped) |=> rdata == 8'h00); // R13

endmodule

bind edge_gpio_ctrl edge_gpio_ctrl_chk #(
   .NUM_BANKS  (NUM_BANKS),
   .BANK_W     (BANK_W),
   .PEND_BASE  (PEND_BASE),
   .MASK_BASE  (MASK_BASE),
   .MASK2_BASE (MASK2_BASE),
   .CTLO_BASE  (CTLO_BASE),
   .CTLI_BASE  (CTLI_BASE),
   .BANK_STRIDE(BANK_STRIDE)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr      (addr),
   .rd_en     (rd_en),
   .rdata     (rdata),
   .pend      (pend_w),
   .mask      (mask_w),
   .hit       (hit_w),
   .clr       (clr_w),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .open_drain(open_drain),
   .irq       (irq)
);

// File: tb/test_edge_gpio_ctrl.sv
module test_edge_gpio_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wdata = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rdata;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out, pin_oe, open_drain, pull_en;
   logic [31:0] pull_sel;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic rd_seen = 1'b0;

   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #10 clk = ~clk; // 50 MHz

   edge_gpio_ctrl i_edge_gpio_ctrl (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .open_drain(open_drain), .pull_en(pull_en),
      .pull_sel(pull_sel), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: compares each read result one edge after the read
   always @(posedge clk) rd_seen <= rd_en;
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) chk(tag_q.pop_front(), {24'h0, rdata}, {24'h0, exp_q.pop_front()});
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
      @(negedge clk); addr = a; rd_en = 1'b1;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk("R1 irq", irq, 0);
      chk("R1 pin_oe", pin_oe, 0);
      chk("R1 pin_out", pin_out, 0);
      rd(8'h2B, 8'h00, "R1 ctlo0");
      rd(8'h33, 8'h00, "R1 ctli0");
      rd(8'h0B, 8'h00, "R1 pend0");
      rd(8'h1A, 8'h00, "R1 mask1");

      // R2 output-control fields
      wr(8'h2E, 8'h2F);
      rd(8'h2E, 8'h2F, "R2 ctlo pin3 readback");
      chk("R2 pin_out3", pin_out[3], 1);
      chk("R2 pull_en3", pull_en[3], 1);
      chk("R2 pull_sel3", pull_sel[7:6], 2'b11);
      chk("R2 od3", open_drain[3], 0);
      chk("R3 oe3", pin_oe[3], 1);
      wr(8'h3D, 8'h13);
      rd(8'h3D, 8'h13, "R2 ctlo pin10 readback");
      chk("R2 od10", open_drain[10], 1);
      chk("R2 pull_sel10", pull_sel[21:20], 2'b01);
      chk("R3 oe10 input", pin_oe[10], 0);

      // R3 open-drain drive
      wr(8'h3D, 8'h31);
      chk("R3 od high released", pin_oe[10], 0);
      wr(8'h3D, 8'h30);
      chk("R3 od low driven", pin_oe[10], 1);
      chk("R3 od low value", pin_out[10], 0);

      // R4 input-control
      pin_in[5] = 1'b1;
      idle(3);
      rd(8'h38, 8'h01, "R4 level pin5");
      wr(8'h38, 8'hFF);
      rd(8'h38, 8'h07, "R4 mode readback");
      wr(8'h38, 8'h00);
      rd(8'h38, 8'h01, "R4 mode cleared");

      // R5 falling on pin1
      wr(8'h34, 8'h02);
      pin_in[1] = 1'b1; idle(4);
      rd(8'h0B, 8'h00, "R5 rise ignored");
      pin_in[1] = 1'b0; idle(4);
      rd(8'h0B, 8'h02, "R5 fall latched");
      chk("R11 irq on pend", irq, 1);
      wr(8'h0B, 8'h02); idle(2);
      rd(8'h0B, 8'h00, "R8 cleared");
      chk("R11 irq dropped", irq, 0);

      // R6 rising on pin12
      wr(8'h47, 8'h04);
      pin_in[12] = 1'b1; idle(4);
      rd(8'h0C, 8'h10, "R6 rise latched");
      wr(8'h0C, 8'h10);
      pin_in[12] = 1'b0; idle(4);
      rd(8'h0C, 8'h00, "R6 fall ignored");

      // R7 both on pin7, off on pin6
      wr(8'h3A, 8'h06);
      pin_in[7] = 1'b1; idle(4);
      rd(8'h0B, 8'h80, "R7 both rise");
      wr(8'h0B, 8'h80);
      pin_in[7] = 1'b0; idle(4);
      rd(8'h0B, 8'h80, "R7 both fall");
      wr(8'h0B, 8'h80);
      pin_in[6] = 1'b1; idle(4);
      pin_in[6] = 1'b0; idle(4);
      rd(8'h0B, 8'h00, "R7 mode off");

      // R8 partial clear
      pin_in[1] = 1'b1; pin_in[7] = 1'b1; idle(4);
      pin_in[1] = 1'b0; idle(4);
      rd(8'h0B, 8'h82, "R8 two pending");
      wr(8'h0B, 8'h02);
      rd(8'h0B, 8'h80, "R8 zero bit kept");
      wr(8'h0B, 8'h80);
      rd(8'h0B, 8'h00, "R8 all clear");

      // R10 mask
      wr(8'h19, 8'h80);
      rd(8'h19, 8'h80, "R10 mask readback");
      pin_in[7] = 1'b0; idle(5);
      chk("R10 masked irq", irq, 0);
      rd(8'h0B, 8'h80, "R10 pend visible");
      wr(8'h19, 8'h00); idle(2);
      chk("R10 unmasked irq", irq, 1);
      wr(8'h0B, 8'h80); idle(2);
      chk("R10 irq after clear", irq, 0);

      // R11 exact latency
      @(negedge clk); pin_in[7] = 1'b1;
      idle(3);
      chk("R11 irq not yet", irq, 0);
      idle(1);
      chk("R11 irq at 4th edge", irq, 1);

      // R9 edge and clear on the same edge
      @(negedge clk); pin_in[7] = 1'b0;
      idle(2);
      addr = 8'h0B; wdata = 8'h80; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      rd(8'h0B, 8'h80, "R9 edge beats clear");
      wr(8'h0B, 8'h80);
      rd(8'h0B, 8'h00, "R9 later clear");

      // R12 secondary mask
      pin_in[7] = 1'b1; idle(5);
      wr(8'h1B, 8'hFF);
      wr(8'h1C, 8'h5A);
      rd(8'h1B, 8'hFF, "R12 mask2 bank0");
      rd(8'h1C, 8'h5A, "R12 mask2 bank1");
      chk("R12 irq unaffected", irq, 1);
      wr(8'h0B, 8'h80);

      // R13 unmapped and pending not settable
      wr(8'h00, 8'hFF);
      wr(8'h4B, 8'hFF);
      wr(8'h0C, 8'hFF);
      rd(8'h00, 8'h00, "R13 addr 00");
      rd(8'h4B, 8'h00, "R13 addr 4B");
      rd(8'h20, 8'h00, "R13 addr 20");
      rd(8'h0C, 8'h00, "R13 pend not set");
      chk("R13 oe unchanged", pin_oe, 16'h0408);
      chk("R13 irq quiet", irq, 0);

      idle(2);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule